// File: doc/BRIEF.md
# Dual-Ratio Synchronous Clock Divider

This block derives two slower clocks from one input clock. Bank A runs at one half or one quarter of the input rate. Bank B runs at one quarter, one fifth or one sixth of it. Both banks are registers clocked by the same rising input edge. They start from a common phase, so every rising edge the two outputs share falls on the same input edge.

A run/hold control is active low. It is captured on the falling input edge, so the dividers start or stop only while the input clock is low. A held divider keeps its count and output level, and carries on from that point when released. An active-high master reset clears both banks at once, whatever the clock and the run control are doing. Several copies can then be released together and stay in phase. When all controls are low, the block runs A at /2 and B at /4, out of reset.

Top module: `dual_ratio_clkdiv`

## Requirements
- R1: While masterRst is high, qA and qB are low. The reset acts at once, without a clock edge, and holds whatever the state of enableN.
- R2: Bank A period: ratioSelA = 0 gives a period of 2 input cycles with 1 cycle high. ratioSelA = 1 gives 4 cycles with 2 high.
- R3: Bank B period depends on ratioSelB. Code 2'b00 gives 4 cycles, 2 high. Code 2'b01 gives 6 cycles, 3 high. Codes 2'b10 and 2'b11 give 5 cycles: 2 high, then 3 low.
- R4: After masterRst falls with enableN low, qA and qB both go high on the first rising input edge that follows a falling edge. From then on, each output at the i-th running edge (i from 0) is high when i mod N is below N/2, rounded down.
- R5: enableN is sampled on the falling input edge. A value that is present at a falling edge governs the next rising edge. While it is high, both outputs and both counters hold.
- R6: The outputs change only at rising input edges. Every high or low level therefore lasts at least one whole input cycle.
- R7: A new select value takes effect from the next rising edge. After one old output period, the output runs at the new ratio.
- R8: Bank B's rising edges fall on bank A rising edges whenever bank B's ratio is a multiple of bank A's ratio.
- R9: After a hold, the pattern continues from the point where it stopped, with no skipped or repeated step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Input clock |
| enableN | input | 1 | Run control, active low, sampled on the falling edge |
| masterRst | input | 1 | Asynchronous master reset, active high |
| ratioSelA | input | 1 | Bank A ratio select (0: /2, 1: /4) |
| ratioSelB | input | 2 | Bank B ratio select (00: /4, 01: /6, 1x: /5) |
| qA | output | 1 | Bank A divided clock |
| qB | output | 1 | Bank B divided clock |

## Verification
Each output takes its new level at the rising edge that computes it. The bench drives inputs and samples outputs 2 ns after each rising edge, which is before the falling edge that captures the run control. A change made there therefore governs the following rising edge. One test drives enableN just after a falling edge instead, and expects one more running edge before the hold begins. Reset is checked 1 ns after it is raised, and again at later edges. Ratio changes are measured only after a settling window longer than the longest old period. A separate monitor compares each output just after the falling edge with its value after the rising edge, to show that no level changes mid-cycle.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Counter width: must hold the largest ratio minus one, plus a spare reset code.
  parameter int CNT_W = 3;
  parameter int NUM_BANKS = 2;

  // Selectable ratios.
  parameter int A_RATIO_FAST = 2;
  parameter int A_RATIO_SLOW = 4;
  parameter int B_RATIO_LL   = 4;
  parameter int B_RATIO_LH   = 6;
  parameter int B_RATIO_H    = 5;

  localparam int B_MAX_RATIO =
    (B_RATIO_LH > B_RATIO_H) ? ((B_RATIO_LH > B_RATIO_LL) ? B_RATIO_LH : B_RATIO_LL)
                             : ((B_RATIO_H  > B_RATIO_LL) ? B_RATIO_H  : B_RATIO_LL);
  // Longest level of bank B: the low phase, which is the ceiling of half the ratio.
  localparam int MAX_LEVEL_RUN = B_MAX_RATIO - B_MAX_RATIO / 2;

  // Strobes and limits handed from control to datapath.
  typedef struct packed {
    logic             advance;
    logic [CNT_W-1:0] lastA;
    logic [CNT_W-1:0] highA;
    logic [CNT_W-1:0] lastB;
    logic [CNT_W-1:0] highB;
  } divCmd_t;

  function automatic logic [CNT_W-1:0] lastOf(input int ratio);
    return CNT_W'(ratio - 1);
  endfunction

  function automatic logic [CNT_W-1:0] highOf(input int ratio);
    return CNT_W'(ratio / 2);
  endfunction

endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic       clkIn,
  input  logic       masterRst,
  input  logic       enableN,
  input  logic       ratioSelA,
  input  logic [1:0] ratioSelB,
  output divCmd_t    cmd
);

  // Run latch on the falling edge: the counters never see it change while
  // the clock is high, so gating cannot clip an output level.
  logic runLatched;

  always_ff @(negedge clkIn or posedge masterRst) begin
    if (masterRst) runLatched <= 1'b0;
    else           runLatched <= ~enableN;
  end

  always_comb begin
    cmd.advance = runLatched;
    if (ratioSelA) begin
      cmd.lastA = lastOf(A_RATIO_SLOW);
      cmd.highA = highOf(A_RATIO_SLOW);
    end else begin
      cmd.lastA = lastOf(A_RATIO_FAST);
      cmd.highA = highOf(A_RATIO_FAST);
    end
    case (ratioSelB)
      2'b00: begin
        cmd.lastB = lastOf(B_RATIO_LL);
        cmd.highB = highOf(B_RATIO_LL);
      end
      2'b01: begin
        cmd.lastB = lastOf(B_RATIO_LH);
        cmd.highB = highOf(B_RATIO_LH);
      end
      default: begin
        cmd.lastB = lastOf(B_RATIO_H);
        cmd.highB = highOf(B_RATIO_H);
      end
    endcase
  end

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
  parameter int CNT_W = clkdiv_pkg::CNT_W
) (
  input  logic             clkIn,
  input  logic             masterRst,
  input  logic             advance,
  input  logic [CNT_W-1:0] lastCount,
  input  logic [CNT_W-1:0] highCount,
  output logic             qOut
);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] countNext;

  // Any count at or past the last step wraps to zero. That covers a shrinking
  // ratio and the all-ones reset code, so the first running edge lands on phase 0.
  always_comb begin
    if (count >= lastCount) countNext = '0;
    else                    countNext = count + 1'b1;
  end

  always_ff @(posedge clkIn or posedge masterRst) begin
    if (masterRst) begin
      count <= '1;
      qOut  <= 1'b0;
    end else if (advance) begin
      count <= countNext;
      qOut  <= (countNext < highCount);
    end
  end

endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
(
  input  logic    clkIn,
  input  logic    masterRst,
  input  divCmd_t cmd,
  output logic    qA,
  output logic    qB
);

  logic [CNT_W-1:0]     lastSel [NUM_BANKS];
  logic [CNT_W-1:0]     highSel [NUM_BANKS];
  logic [NUM_BANKS-1:0] qVec;

  assign lastSel[0] = cmd.lastA;
  assign highSel[0] = cmd.highA;
  assign lastSel[1] = cmd.lastB;
  assign highSel[1] = cmd.highB;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    clkdiv_bank #(.CNT_W(CNT_W)) u_bank (
      .clkIn     (clkIn),
      .masterRst (masterRst),
      .advance   (cmd.advance),
      .lastCount (lastSel[b]),
      .highCount (highSel[b]),
      .qOut      (qVec[b])
    );
  end

  assign qA = qVec[0];
  assign qB = qVec[1];

endmodule

// File: rtl/dual_ratio_clkdiv.sv
module dual_ratio_clkdiv
  import clkdiv_pkg::*;
(
  input  logic       clkIn,
  input  logic       enableN,
  input  logic       masterRst,
  input  logic       ratioSelA,
  input  logic [1:0] ratioSelB,
  output logic       qA,
  output logic       qB
);

  divCmd_t divCmd;
  logic    advanceNow;

  clkdiv_ctrl u_ctrl (
    .clkIn     (clkIn),
    .masterRst (masterRst),
    .enableN   (enableN),
    .ratioSelA (ratioSelA),
    .ratioSelB (ratioSelB),
    .cmd       (divCmd)
  );

  clkdiv_datapath u_dp (
    .clkIn     (clkIn),
    .masterRst (masterRst),
    .cmd       (divCmd),
    .qA        (qA),
    .qB        (qB)
  );

  assign advanceNow = divCmd.advance;

endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker
  import clkdiv_pkg::*;
(
  input logic       clkIn,
  input logic       masterRst,
  input logic       ratioSelA,
  input logic [1:0] ratioSelB,
  input logic       advanceNow,
  input logic       qA,
  input logic       qB
);

  // Counts the running edges over which qB has kept the same level.
  logic [3:0] runLen;
  logic       prevQB;
  logic       prevAdv;
  logic [2:0] prevSel;

  always_ff @(posedge clkIn or posedge masterRst) begin
    if (masterRst) begin
      runLen  <= '0;
      prevQB  <= 1'b0;
      prevAdv <= 1'b0;
      prevSel <= '0;
    end else begin
      prevQB  <= qB;
      prevAdv <= advanceNow;
      prevSel <= {ratioSelA, ratioSelB};
      if (prevSel != {ratioSelA, ratioSelB}) runLen <= '0;
      else if (prevAdv)                      runLen <= (qB == prevQB) ? runLen + 4'd1 : 4'd1;
    end
  end

  // R1: both outputs cleared while reset is applied
  always @(negedge clkIn) begin
    if (masterRst) begin
      assert_reset_clear_R1: assert (!qA && !qB);
    end
  end

  // R5: an edge without the run strobe leaves both outputs untouched
  assert_hold_stable_R5: assert property (@(posedge clkIn) disable iff (masterRst)
    !advanceNow |=> ($stable(qA) && $stable(qB)));

  // R2: in the /2 setting, bank A flips on every running edge once settled
  assert_div2_toggle_R2: assert property (@(posedge clkIn) disable iff (masterRst)
    (advanceNow && !ratioSelA && $past(advanceNow) && !$past(ratioSelA))
      |=> (qA != $past(qA)));

  // R3: with a steady select, no bank B level outlasts the longest phase
  assert_run_bound_R3: assert property (@(posedge clkIn) disable iff (masterRst)
    runLen <= 4'(MAX_LEVEL_RUN));

endmodule

bind dual_ratio_clkdiv clkdiv_checker u_chk (
  .clkIn      (clkIn),
  .masterRst  (masterRst),
  .ratioSelA  (ratioSelA),
  .ratioSelB  (ratioSelB),
  .advanceNow (advanceNow),
  .qA         (qA),
  .qB         (qB)
);

// File: tb/tb_dual_ratio_clkdiv.sv
`timescale 1ns/1ps
module tb_dual_ratio_clkdiv;

  logic       clkIn = 1'b0;
  logic       enableN = 1'b0;
  logic       masterRst = 1'b0;
  logic       ratioSelA = 1'b0;
  logic [1:0] ratioSelB = 2'b00;
  logic       qA;
  logic       qB;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clkIn = ~clkIn;

  dual_ratio_clkdiv dut (
    .clkIn(clkIn), .enableN(enableN), .masterRst(masterRst),
    .ratioSelA(ratioSelA), .ratioSelB(ratioSelB), .qA(qA), .qB(qB)
  );

  function automatic int ratioOfA(input logic s);
    return s ? 4 : 2;
  endfunction

  function automatic int ratioOfB(input logic [1:0] c);
    case (c)
      2'b00:   return 4;
      2'b01:   return 6;
      default: return 5;
    endcase
  endfunction

  function automatic int levelAt(input int i, input int n);
    return ((i % n) < (n / 2)) ? 1 : 0;
  endfunction

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic stepEdge();
    @(posedge clkIn);
    #2;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // R6 monitor: level just after the falling edge must match the level after the rising edge
  logic snapA, snapB, snapRst;
  bit   snapValid = 1'b0;
  always @(posedge clkIn) begin
    #2;
    snapA = qA;
    snapB = qB;
    snapRst = masterRst;
    snapValid = 1'b1;
  end
  always @(negedge clkIn) begin
    #1;
    if (snapValid && !snapRst && !masterRst && !finished) begin
      checkEq("R6 qA steady through low phase", qA, snapA);
      checkEq("R6 qB steady through low phase", qB, snapB);
    end
  end

  initial begin
    #(200000 * 8);
    checks++;
    failures++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    int na, nb, pa, pb, j;
    logic sa;
    logic [1:0] sb;
    int r0, r1, a0, a1;

    #1 masterRst = 1'b1;
    repeat (3) stepEdge();
    checkEq("R1 qA at reset", qA, 0);
    checkEq("R1 qB at reset", qB, 0);

    // Sweep of every select combination from a fresh reset
    for (int cfg = 0; cfg < 8; cfg++) begin
      sa = cfg[2];
      sb = cfg[1:0];
      na = ratioOfA(sa);
      nb = ratioOfB(sb);
      masterRst = 1'b1;
      stepEdge();
      stepEdge();
      checkEq("R1 qA held low with run active", qA, 0);
      checkEq("R1 qB held low with run active", qB, 0);
      ratioSelA = sa;
      ratioSelB = sb;
      masterRst = 1'b0;
      pa = 0;
      pb = 0;
      for (int i = 0; i < 30; i++) begin
        stepEdge();
        checkEq($sformatf("R2 qA cfg=%0d edge=%0d", cfg, i), qA, levelAt(i, na));
        checkEq($sformatf("R3 qB cfg=%0d edge=%0d", cfg, i), qB, levelAt(i, nb));
        if (i == 0) checkEq("R4 both rise on first edge", (qA && qB) ? 1 : 0, 1);
        if (i > 0 && qB && !pb && (nb % na == 0))
          checkEq($sformatf("R8 qA rises with qB cfg=%0d", cfg), (qA && !pa) ? 1 : 0, 1);
        pa = qA;
        pb = qB;
      end
    end

    // Hold and resume: A /4, B /5
    masterRst = 1'b1;
    stepEdge();
    ratioSelA = 1'b1;
    ratioSelB = 2'b10;
    masterRst = 1'b0;
    na = 4;
    nb = 5;
    for (int i = 0; i <= 6; i++) begin
      stepEdge();
      checkEq("R2 qA before hold", qA, levelAt(i, na));
      checkEq("R3 qB before hold", qB, levelAt(i, nb));
    end
    enableN = 1'b1;
    for (int h = 0; h < 5; h++) begin
      stepEdge();
      checkEq("R5 qA frozen", qA, levelAt(6, na));
      checkEq("R5 qB frozen", qB, levelAt(6, nb));
    end
    enableN = 1'b0;
    for (int i = 7; i <= 16; i++) begin
      stepEdge();
      checkEq("R9 qA resumes in sequence", qA, levelAt(i, na));
      checkEq("R9 qB resumes in sequence", qB, levelAt(i, nb));
    end

    // Run control changed just after a falling edge: one more running edge
    #4;
    enableN = 1'b1;
    stepEdge();
    checkEq("R5 late hold not yet seen qA", qA, levelAt(17, na));
    checkEq("R5 late hold not yet seen qB", qB, levelAt(17, nb));
    stepEdge();
    checkEq("R5 late hold applied qA", qA, levelAt(17, na));
    checkEq("R5 late hold applied qB", qB, levelAt(17, nb));
    enableN = 1'b0;
    for (j = 18; j <= 25; j++) begin
      stepEdge();
      checkEq("R9 qA after late hold", qA, levelAt(j, na));
      checkEq("R9 qB after late hold", qB, levelAt(j, nb));
    end

    // Select change on the fly: A to /2, B to /6
    ratioSelA = 1'b0;
    ratioSelB = 2'b01;
    repeat (12) stepEdge();
    r0 = -1; r1 = -1; a0 = -1; a1 = -1;
    pa = qA;
    pb = qB;
    for (int k = 0; k < 30; k++) begin
      stepEdge();
      if (qB && !pb) begin
        if (r0 < 0) r0 = k;
        else if (r1 < 0) r1 = k;
      end
      if (qA && !pa) begin
        if (a0 < 0) a0 = k;
        else if (a1 < 0) a1 = k;
      end
      pa = qA;
      pb = qB;
    end
    checkEq("R7 bank B period after select change", r1 - r0, 6);
    checkEq("R7 bank A period after select change", a1 - a0, 2);

    // Reset applied mid-run acts without a clock edge
    masterRst = 1'b1;
    #1;
    checkEq("R1 qA cleared asynchronously", qA, 0);
    checkEq("R1 qB cleared asynchronously", qB, 0);
    stepEdge();
    stepEdge();
    checkEq("R1 qA stays low in reset", qA, 0);
    checkEq("R1 qB stays low in reset", qB, 0);
    masterRst = 1'b0;
    stepEdge();
    checkEq("R4 qA first edge after release", qA, 1);
    checkEq("R4 qB first edge after release", qB, 1);

    finishRun();
  end

endmodule